// File: doc/BRIEF.md
# Supply Rail Start-Up Sequencer

This block brings up four supply rails for a display panel in a fixed order and guards them afterwards. The rails are a boost rail, a logic rail, a negative gate rail and a positive gate rail. A prescaled tick counter stands in for an external timing capacitor. It produces six ramp phases, and each phase has a rising half followed by a falling half. The end of the rising half is the ramp's peak. The rail enables, the input-protection gate and the delayed-boost gate each switch at a fixed ramp start or ramp peak.

The flag inputs are asynchronous and come from analog comparators. Each flag is registered through two flops before the controller uses it. After power-up the block watches the fault flags. A timing, reference or temperature fault shuts the block down at once. An under-voltage flag starts a fault timer, which either expires into shutdown or is discarded when the flag clears. A shutdown is latched until the enable goes low or the supply-good flag drops. The ramp half length, the soft-start length, the fault timeout and the tick prescaler are all inputs, so every delay scales with one setting.

Top module: `rail_seq`

## Requirements
- R1: When the synchronised enable or supply-good flag is low, the block returns to IDLE and stays there. In IDLE all rail enables and soft-start are 0, both gates are high, and the cause code is 0.
- R2: The block leaves IDLE for ramp 1 only when enable and supply-good are both high and the timing-low flag is clear.
- R3: The protection gate goes low at the peak of ramp 2, exactly ramp_ticks ticks before the boost rail turns on.
- R4: The boost and logic enables rise together at the start of ramp 3. Soft-start is high for exactly ss_ticks ticks from that point.
- R5: The negative rail turns on at the peak of ramp 4, 3·ramp_ticks ticks after boost. The delayed-boost gate falls at the peak of ramp 5, 2·ramp_ticks ticks after that. The positive rail turns on at the start of ramp 6, ramp_ticks ticks later still. One tick is (presc+1) clock cycles.
- R6: At the end of ramp 6 the block moves to RUN if no under-voltage flag is set. If any under-voltage flag is set, it moves to OFF with that flag's cause code.
- R7: In any ramp phase or in RUN or fault-timing, a timing-low fault or a reference fault sends the block to OFF at once. An over-temperature fault does the same, but is ignored in ramp 1. In RUN or fault-timing, timing-high is also a fault.
- R8: An under-voltage flag in RUN moves the block to fault-timing (phase 8). If the flag clears before the timeout, the block goes back to RUN and the cause code stays 0.
- R9: If an under-voltage flag is still set when fto_ticks ticks have passed in fault-timing, the block moves to OFF.
- R10: OFF turns every rail and soft-start off and holds both gates high. The block stays in OFF after the faults clear, and leaves only when enable or supply-good goes low.
- R11: While timing-high is set during a ramp, the rising half never ends, so the phase does not advance. Once timing-high clears, the sequence resumes.
- R12: Phase codes are IDLE=0, ramps 1 to 6 = 1 to 6, RUN=7, fault-timing=8 and OFF=9. Cause codes are timing=1, reference=2, over-temperature=3, boost UV=4, logic UV=5, negative UV=6 and positive UV=7. When several faults arrive together, the lowest code wins. Once set, the cause code holds until R1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Enable (asynchronous) |
| supply_ok_i | input | 1 | Input supply above start threshold |
| tnode_lo_i | input | 1 | Timing node stuck low |
| tnode_hi_i | input | 1 | Timing node stuck high |
| ref_bad_i | input | 1 | Reference out of range |
| hot_i | input | 1 | Over-temperature |
| uv_boost_i | input | 1 | Boost rail under-voltage |
| uv_logic_i | input | 1 | Logic rail under-voltage |
| uv_neg_i | input | 1 | Negative rail under-voltage |
| uv_pos_i | input | 1 | Positive rail under-voltage |
| presc_i | input | PW | Tick period minus one, in clocks |
| ramp_ticks_i | input | TW | Ticks per ramp half (nonzero) |
| ss_ticks_i | input | TW | Soft-start length in ticks |
| fto_ticks_i | input | TW | Fault timeout in ticks (nonzero) |
| boost_en_o | output | 1 | Boost rail enable |
| logic_en_o | output | 1 | Logic rail enable |
| neg_en_o | output | 1 | Negative rail enable |
| pos_en_o | output | 1 | Positive rail enable |
| ss_o | output | 1 | Soft-start request |
| prot_gate_n_o | output | 1 | Input-protection gate, low = on |
| dly_gate_n_o | output | 1 | Delayed-boost gate, low = on |
| phase_o | output | 4 | Current phase code |
| cause_o | output | 3 | Sticky first-fault cause |

## Verification
A clean power-up is run at two prescaler settings. Timing the gaps between the edges of the gates and enables separates a wrong ramp position or a wrong peak/start choice from a wrong tick scale. In directed cases a fault is raised in ramp 1, in ramp 6, or while timing-high is stuck, and these separate the per-phase checking windows. Random fault vectors applied in RUN, with a bench function that computes the expected priority code, cover three distinctions: hard faults against timed faults, the cause priority, and the OFF latch. Short under-voltage pulses show that the fault timer recovers.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int TW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          supply_ok_i,
  input  logic          tnode_lo_i,
  input  logic          tnode_hi_i,
  input  logic          ref_bad_i,
  input  logic          hot_i,
  input  logic          uv_boost_i,
  input  logic          uv_logic_i,
  input  logic          uv_neg_i,
  input  logic          uv_pos_i,
  input  logic [PW-1:0] presc_i,
  input  logic [TW-1:0] ramp_ticks_i,
  input  logic [TW-1:0] ss_ticks_i,
  input  logic [TW-1:0] fto_ticks_i,
  output logic          boost_en_o,
  output logic          logic_en_o,
  output logic          neg_en_o,
  output logic          pos_en_o,
  output logic          ss_o,
  output logic          prot_gate_n_o,
  output logic          dly_gate_n_o,
  output logic [3:0]    phase_o,
  output logic [2:0]    cause_o
);
  localparam int NS = 10;
  localparam logic [3:0] IDLE = 4'd0, RUN = 4'd7, FTO = 4'd8, OFF = 4'd9;

  logic [NS-1:0] s1, s2, raw;
  assign raw = {uv_pos_i, uv_neg_i, uv_logic_i, uv_boost_i, hot_i, ref_bad_i,
                tnode_hi_i, tnode_lo_i, supply_ok_i, en_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin s1 <= '0; s2 <= '0; end
    else begin s1 <= raw; s2 <= s1; end

  logic en_s, ok_s, tlo, thi, refb, hot;
  logic [3:0] uv;
  assign {uv, hot, refb, thi, tlo, ok_s, en_s} = s2;

  logic [PW-1:0] pc;
  logic [3:0]    phase;
  logic          half;
  logic [TW-1:0] tc, ft, ssc;
  logic [2:0]    cause, hard, uv_code;
  logic          tick, ramp, active, half_end;

  assign tick     = (pc == presc_i);
  assign ramp     = (phase >= 4'd1) && (phase <= 4'd6);
  assign active   = (phase >= 4'd1) && (phase <= FTO);
  assign half_end = tick && (tc == ramp_ticks_i - TW'(1));

  always_comb begin
    if (tlo || (thi && !ramp))       hard = 3'd1;
    else if (refb)                   hard = 3'd2;
    else if (hot && phase >= 4'd2)   hard = 3'd3;
    else                             hard = 3'd0;
    if (uv[0])      uv_code = 3'd4;
    else if (uv[1]) uv_code = 3'd5;
    else if (uv[2]) uv_code = 3'd6;
    else if (uv[3]) uv_code = 3'd7;
    else            uv_code = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; phase <= IDLE; half <= 1'b0; tc <= '0; ft <= '0; ssc <= '0; cause <= '0;
    end else begin
      pc <= tick ? '0 : pc + PW'(1);
      if (tick && ssc != '0) ssc <= ssc - TW'(1);
      if (!en_s || !ok_s) begin
        phase <= IDLE; half <= 1'b0; tc <= '0; ft <= '0; ssc <= '0; cause <= '0;
      end else if (phase == IDLE) begin
        if (!tlo) begin phase <= 4'd1; half <= 1'b0; tc <= '0; end
      end else if (phase == OFF) begin
        ssc <= '0;
      end else if (hard != 3'd0) begin
        phase <= OFF; ssc <= '0;
        if (cause == 3'd0) cause <= hard;
      end else if (ramp) begin
        if (tick) begin
          if (!half_end) tc <= tc + TW'(1);
          else if (!half) begin
            if (!thi) begin half <= 1'b1; tc <= '0; end
          end else begin
            half <= 1'b0; tc <= '0;
            if (phase == 4'd2) ssc <= ss_ticks_i;
            if (phase == 4'd6) begin
              if (uv_code != 3'd0) begin phase <= OFF; cause <= uv_code; end
              else phase <= RUN;
            end else phase <= phase + 4'd1;
          end
        end
      end else if (phase == RUN) begin
        if (uv_code != 3'd0) begin phase <= FTO; ft <= '0; end
      end else begin
        if (uv_code == 3'd0) phase <= RUN;
        else if (tick) begin
          if (ft == fto_ticks_i - TW'(1)) begin phase <= OFF; cause <= uv_code; end
          else ft <= ft + TW'(1);
        end
      end
    end
  end

  assign boost_en_o    = active && phase >= 4'd3;
  assign logic_en_o    = boost_en_o;
  assign neg_en_o      = active && (phase > 4'd4 || (phase == 4'd4 && half));
  assign pos_en_o      = active && phase >= 4'd6;
  assign ss_o          = active && ssc != '0;
  assign prot_gate_n_o = !(active && (phase > 4'd2 || (phase == 4'd2 && half)));
  assign dly_gate_n_o  = !(active && (phase > 4'd5 || (phase == 4'd5 && half)));
  assign phase_o       = phase;
  assign cause_o       = cause;

  p_drop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s || !ok_s) |=> (phase == IDLE && cause == 3'd0));
  p_off_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == OFF && en_s && ok_s) |=> phase == OFF);
  p_fto_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == FTO && uv_code == 3'd0 && hard == 3'd0 && en_s && ok_s) |=> phase == RUN);
  p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != 3'd0 && en_s && ok_s) |=> $stable(cause));
  p_run_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == RUN) |-> ($past(phase) == 4'd6 || $past(phase) == FTO));
  p_prot_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_gate_n_o) |-> (phase == 4'd2 && half));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp && !half && thi && half_end && hard == 3'd0 && en_s && ok_s) |=> (phase == $past(phase) && !half));
endmodule

// File: tb/rail_seq_tb.sv
module rail_seq_tb;
  logic clk = 0, rst_n = 0, en = 0, ok = 0;
  logic [7:0] f = '0;
  logic [7:0] presc = '0;
  logic [15:0] rt = 16'd4, sst = 16'd3, fto = 16'd10;
  logic boost_en, logic_en, neg_en, pos_en, ss, prot_n, dly_n;
  logic [3:0] phase;
  logic [2:0] cause;
  int nchk = 0, nfail = 0, cyc = 0;
  int t_prot, t_boost, t_logic, t_neg, t_dly, t_pos, ss_len;
  bit rec = 0, done = 0;

  always #5 clk = ~clk;

  rail_seq u_dut (.clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(ok),
    .tnode_lo_i(f[0]), .tnode_hi_i(f[1]), .ref_bad_i(f[2]), .hot_i(f[3]),
    .uv_boost_i(f[4]), .uv_logic_i(f[5]), .uv_neg_i(f[6]), .uv_pos_i(f[7]),
    .presc_i(presc), .ramp_ticks_i(rt), .ss_ticks_i(sst), .fto_ticks_i(fto),
    .boost_en_o(boost_en), .logic_en_o(logic_en), .neg_en_o(neg_en), .pos_en_o(pos_en),
    .ss_o(ss), .prot_gate_n_o(prot_n), .dly_gate_n_o(dly_n), .phase_o(phase), .cause_o(cause));

  always @(negedge clk) begin
    cyc++;
    if (rec) begin
      if (t_prot  < 0 && !prot_n)  t_prot  = cyc;
      if (t_boost < 0 && boost_en) t_boost = cyc;
      if (t_logic < 0 && logic_en) t_logic = cyc;
      if (t_neg   < 0 && neg_en)   t_neg   = cyc;
      if (t_dly   < 0 && !dly_n)   t_dly   = cyc;
      if (t_pos   < 0 && pos_en)   t_pos   = cyc;
      if (ss) ss_len++;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wait_phase(input int p, input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (phase == p) begin hit = 1; break; end
    end
  endtask

  function automatic int exp_cause(input logic [7:0] v);
    if (v[0] || v[1]) return 1;
    if (v[2]) return 2;
    if (v[3]) return 3;
    if (v[4]) return 4;
    if (v[5]) return 5;
    if (v[6]) return 6;
    if (v[7]) return 7;
    return 0;
  endfunction

  task automatic restart(output bit hit);
    en = 0; f = '0;
    repeat (5) @(negedge clk);
    en = 1;
    wait_phase(7, 4000, hit);
  endtask

  task automatic run_seq(input int p);
    bit hit;
    int t;
    presc = 8'(p); en = 0;
    repeat (6) @(negedge clk);
    t_prot = -1; t_boost = -1; t_logic = -1; t_neg = -1; t_dly = -1; t_pos = -1; ss_len = 0;
    rec = 1; en = 1;
    wait_phase(7, 4000, hit);
    rec = 0;
    t = int'(rt) * (p + 1);
    chk("R6 reach RUN", int'(hit), 1);
    chk("R3 prot low to boost on", t_boost - t_prot, t);
    chk("R4 logic with boost", t_logic - t_boost, 0);
    chk("R4 soft-start length", ss_len, int'(sst) * (p + 1));
    chk("R5 boost to neg", t_neg - t_boost, 3 * t);
    chk("R5 neg to delayed gate", t_dly - t_neg, 2 * t);
    chk("R5 delayed gate to pos", t_pos - t_dly, t);
    chk("R12 cause zero in RUN", int'(cause), 0);
  endtask

  initial begin
    bit hit;
    int unsigned seed;
    logic [7:0] v;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset enables", int'({boost_en, logic_en, neg_en, pos_en, ss}), 0);
    chk("R1 reset gates high", int'({prot_n, dly_n}), 3);
    chk("R12 reset cause", int'(cause), 0);

    en = 1; ok = 0;
    repeat (40) @(negedge clk);
    chk("R2 no start without supply", int'(phase), 0);
    ok = 1; f[0] = 1;
    repeat (40) @(negedge clk);
    chk("R2 no start with timing low", int'(phase), 0);
    f[0] = 0;
    wait_phase(1, 20, hit);
    chk("R2 start once clear", int'(hit), 1);

    run_seq(0);
    run_seq(2);

    presc = 0;
    f[6] = 1; wait_phase(8, 20, hit);
    chk("R8 enter fault timing", int'(hit), 1);
    f[6] = 0; wait_phase(7, 20, hit);
    chk("R8 recover to RUN", int'(hit), 1);
    chk("R8 cause untouched", int'(cause), 0);

    f[7] = 1;
    repeat (int'(fto) + 10) @(negedge clk);
    chk("R9 timeout to OFF", int'(phase), 9);
    chk("R12 positive UV cause", int'(cause), 7);
    f = '0;
    repeat (30) @(negedge clk);
    chk("R10 stays OFF", int'(phase), 9);
    chk("R10 outputs off", int'({boost_en, neg_en, pos_en, ss, prot_n, dly_n}), 3);
    en = 0;
    repeat (5) @(negedge clk);
    chk("R1 toggle clears to IDLE", int'(phase), 0);
    chk("R1 cause cleared", int'(cause), 0);

    en = 1; wait_phase(1, 20, hit);
    f[2] = 1; wait_phase(9, 20, hit);
    chk("R7 reference fault in ramp", int'(hit), 1);
    chk("R12 reference cause", int'(cause), 2);

    en = 0; f = '0; repeat (5) @(negedge clk);
    en = 1; wait_phase(1, 20, hit);
    f[3] = 1; wait_phase(2, 40, hit);
    chk("R7 hot ignored in ramp 1", int'(hit), 1);
    wait_phase(9, 20, hit);
    chk("R7 hot trips from ramp 2", int'(hit), 1);
    chk("R12 hot cause", int'(cause), 3);

    en = 0; f = '0; repeat (5) @(negedge clk);
    f[1] = 1; en = 1; wait_phase(1, 20, hit);
    repeat (60) @(negedge clk);
    chk("R11 stalled in ramp 1", int'(phase), 1);
    chk("R11 prot gate still high", int'(prot_n), 1);
    f[1] = 0; wait_phase(7, 2000, hit);
    chk("R11 resumes after clear", int'(hit), 1);

    en = 0; repeat (5) @(negedge clk);
    en = 1; wait_phase(6, 2000, hit);
    f[5] = 1; wait_phase(9, 40, hit);
    chk("R6 UV at ramp 6 end", int'(hit), 1);
    chk("R6 logic UV cause", int'(cause), 5);

    restart(hit);
    ok = 0; repeat (5) @(negedge clk);
    chk("R1 supply drop idles", int'(phase), 0);
    chk("R1 supply drop rails off", int'({boost_en, prot_n}), 1);
    ok = 1;

    presc = 1;
    for (int k = 0; k < 16; k++) begin
      restart(hit);
      chk("R6 random bring-up", int'(hit), 1);
      v = 8'($urandom_range(1, 255));
      f = v;
      repeat (int'(fto) * 2 + 20) @(negedge clk);
      chk("R9 random fault to OFF", int'(phase), 9);
      chk("R12 random cause priority", int'(cause), exp_cause(v));
      f = '0;
      repeat (10) @(negedge clk);
      chk("R10 random latch", int'(phase), 9);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule